// File: doc/BRIEF.md
# Fractional-Divider PWM Timebase

This block produces the shared time reference for a group of PWM channels. A counting source is chosen first: either every cycle of the fast bus clock, or the rising edges of a slow reference tick that arrives as a strobe in the same clock domain. That source feeds a fractional divider. The divider takes an unsigned fixed-point value with 10 integer bits and 8 fraction bits, so the average tick rate can be set in steps of 1/256.

Each divided tick advances a counter. The counter wraps after 2^N values, where N is the programmed resolution. N can be set from 1 to 20. The block drives the running count, and a one-cycle overflow strobe at each wrap, to the channels attached to it. The output period is source_rate / ((divider/256) * 2^N).

Software can freeze the timebase with a pause input. It can also restart the timebase with a synchronous clear. A change to the resolution takes effect only at the next wrap or at a clear, so no period is ever cut short.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `count` = 0 and `ovf` = 0.
- R2: With `src_sel` = 0, every clock cycle is one source edge for the divider.
- R3: With `src_sel` = 1, only a 0-to-1 transition of `ref_tick` is a source edge. A level held high counts once, and clock cycles without such a transition do not advance anything.
- R4: After k source edges since a clear, the number of counter advances is floor(256*k/D), where `div_val` = D and 256 <= D <= 0x3FFFF. The low 8 bits of `div_val` are the fraction. The spacing between advances therefore alternates between floor(D/256) and ceil(D/256) edges.
- R5: A `div_val` below 256 acts exactly like 256 (one advance per source edge).
- R6: The counter steps by one per advance and wraps from 2^N-1 to 0, where N = `res_bits`. A `res_bits` of 0 is treated as 1, and a value above 20 is treated as 20.
- R7: `ovf` is high for exactly one cycle, namely the cycle in which `count` has just wrapped to 0.
- R8: While `pause` is high, `count` holds and the divider phase is frozen. Counting resumes from the same point when `pause` is released.
- R9: `cnt_clr` high at an edge sets `count` to 0 and the divider phase to 0 on the next cycle. It takes priority over `pause` and loads the current `res_bits` at once.
- R10: A change of `res_bits` while the counter runs has no effect until the next wrap. The period in progress completes with the old width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked here |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | 0: bus clock is the source; 1: reference tick is the source |
| ref_tick | input | 1 | Slow reference strobe, synchronous to `clk` |
| div_val | input | 18 | Divider, 10.8 unsigned fixed point |
| res_bits | input | 5 | Counter resolution N |
| pause | input | 1 | Hold counter and divider phase |
| cnt_clr | input | 1 | Synchronous counter and divider clear |
| count | output | 20 | Current timebase count |
| ovf | output | 1 | One-cycle strobe on wrap to 0 |

## Verification
The assertions check, on every cycle, the properties that are local in time:
- reset and clear drive the count to zero;
- pause freezes the count;
- the count only stays, steps by one or returns to zero;
- the overflow strobe coincides with a fresh zero and never lasts two cycles.

Some properties depend on history and need the bench's scenarios:
- the exact tick count for a fractional divider, and its floor/ceiling dithering;
- the clamping of small dividers and out-of-range resolutions;
- edge-only counting of the reference tick;
- the deferral of a resolution change to the next wrap.

// File: rtl/pwm_timebase_pkg.sv
// Package: shared widths for the fractional-divider PWM timebase.
// Assumes the divider is unsigned fixed point with FRAC_W fraction bits.
package pwm_timebase_pkg;
    localparam int DIV_W   = 18;   // total divider width (10.8)
    localparam int FRAC_W  = 8;    // fraction bits of the divider
    localparam int RES_W   = 5;    // resolution field width
    localparam int CNT_W   = 20;   // widest counter supported
    localparam int ACC_W   = DIV_W + 1;

    // Limit a requested resolution to the legal range 1..max_bits.
    function automatic logic [RES_W-1:0] clamp_res(input logic [RES_W-1:0] req,
                                                   input int max_bits);
        if (req == '0)
            return RES_W'(1);
        else if (int'(req) > max_bits)
            return RES_W'(max_bits);
        else
            return req;
    endfunction
endpackage

// File: rtl/pwm_src_sel.sv
// Source select: produces one enable per counting-source edge.
// With sel low, every clock cycle is an edge. With sel high, an edge is a
// rising transition of the reference strobe (or its level when REF_EDGE = 0).
// Assumes ref_tick is already synchronous to clk.
module pwm_src_sel #(
    parameter bit REF_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic ref_tick,
    output logic src_en
);
    logic ref_qual;

    generate
        if (REF_EDGE) begin : g_edge
            logic ref_q;
            // Remember last reference level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) ref_q <= 1'b0;
                else        ref_q <= ref_tick;
            end
            assign ref_qual = ref_tick & ~ref_q;
        end else begin : g_level
            assign ref_qual = ref_tick;
        end
    endgenerate

    // Choose between bus clock (every cycle) and qualified reference.
    always_comb src_en = sel ? ref_qual : 1'b1;
endmodule

// File: rtl/pwm_frac_div.sv
// Fractional divider: adds one unit (2^FRAC_W) per source edge. It emits a
// tick and subtracts the divider whenever the sum reaches the divider.
// Divider values below one unit are treated as one unit. hold freezes the
// phase; clr zeroes it and suppresses the tick.
module pwm_frac_div #(
    parameter int DIV_W  = pwm_timebase_pkg::DIV_W,
    parameter int FRAC_W = pwm_timebase_pkg::FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_en,
    input  logic             hold,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] div_eff;
    logic [ACC_W-1:0] sum;
    logic             step;

    // Effective divider, clamped to at least one whole unit.
    always_comb begin
        div_eff = (ACC_W'(div_val) < UNIT) ? UNIT : ACC_W'(div_val);
        sum     = acc + UNIT;
        step    = src_en && !hold && !clr;
        tick    = step && (sum >= div_eff);
    end

    // Accumulator update: add a unit, subtract divider on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (step)
            acc <= tick ? (sum - div_eff) : sum;
    end
endmodule

// File: rtl/pwm_counter.sv
// Wrap counter: advances on tick, wraps after 2^N values and pulses ovf
// on the cycle the count shows the wrapped zero. The requested resolution
// is clamped and loaded only at reset, clear or a wrap.
module pwm_counter #(
    parameter int CNT_W = pwm_timebase_pkg::CNT_W,
    parameter int RES_W = pwm_timebase_pkg::RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [RES_W-1:0] res_req,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic [RES_W-1:0] res_act;
    logic [RES_W-1:0] res_lim;
    logic [CNT_W-1:0] top_val;
    logic             wrap;

    // Clamp request and derive the terminal count of the active width.
    always_comb begin
        res_lim = pwm_timebase_pkg::clamp_res(res_req, CNT_W);
        top_val = CNT_W'((64'd1 << res_act) - 64'd1);
        wrap    = tick && (count == top_val);
    end

    // Count, wrap, strobe and deferred resolution load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count   <= '0;
            ovf     <= 1'b0;
            res_act <= res_lim;
        end else if (wrap) begin
            count   <= '0;
            ovf     <= 1'b1;
            res_act <= res_lim;
        end else begin
            ovf <= 1'b0;
            if (tick) count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
// Top: fractional-divider PWM timebase. Source select feeds the fractional
// divider, whose ticks drive the wrap counter. pause freezes divider and
// counter; cnt_clr restarts both and takes priority over pause.
module pwm_timebase #(
    parameter int DIV_W    = pwm_timebase_pkg::DIV_W,
    parameter int FRAC_W   = pwm_timebase_pkg::FRAC_W,
    parameter int RES_W    = pwm_timebase_pkg::RES_W,
    parameter int CNT_W    = pwm_timebase_pkg::CNT_W,
    parameter bit REF_EDGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div_val,
    input  logic [RES_W-1:0] res_bits,
    input  logic             pause,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic src_en;
    logic tick;

    pwm_src_sel #(.REF_EDGE(REF_EDGE)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (src_sel),
        .ref_tick (ref_tick),
        .src_en   (src_en)
    );

    pwm_frac_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_en  (src_en),
        .hold    (pause),
        .clr     (cnt_clr),
        .div_val (div_val),
        .tick    (tick)
    );

    pwm_counter #(.CNT_W(CNT_W), .RES_W(RES_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr     (cnt_clr),
        .res_req (res_bits),
        .count   (count),
        .ovf     (ovf)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
// Checker: cycle-level properties of the timebase ports, bound to the top.
module pwm_timebase_chk #(
    parameter int CNT_W = pwm_timebase_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pause,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] count,
    input logic             ovf
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (count == '0 && !ovf)); // R1
    AST_CLR_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) cnt_clr |=> (count == '0 && !ovf)); // R9
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (pause && !cnt_clr) |=> $stable(count)); // R8
    AST_STEP_ONE:   assert property (@(posedge clk) disable iff (!rst_n) (!cnt_clr && !pause) |=> (count == $past(count) || count == $past(count) + CNT_W'(1) || count == '0)); // R6
    AST_OVF_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) ovf |-> (count == '0)); // R7
    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> !ovf); // R7
    AST_OVF_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> $past(count) != '0); // R7
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pause   (pause),
    .cnt_clr (cnt_clr),
    .count   (count),
    .ovf     (ovf)
);

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_sel = 1'b0;
    logic        ref_tick = 1'b0;
    logic [17:0] div_val = 18'd256;
    logic [4:0]  res_bits = 5'd4;
    logic        pause = 1'b0;
    logic        cnt_clr = 1'b0;
    logic [19:0] count;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    int ovf_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_timebase u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ref_tick(ref_tick),
        .div_val(div_val), .res_bits(res_bits), .pause(pause),
        .cnt_clr(cnt_clr), .count(count), .ovf(ovf)
    );

    typedef struct packed {
        logic [17:0] div;
        logic [4:0]  res;
        logic [15:0] cycles;
        logic [19:0] exp_cnt;
        logic [7:0]  exp_ovf;
    } vec_t;

    // Fast source; expected advances = floor(256*cycles/div), wraps at 2^N.
    localparam vec_t VECS [8] = '{
        '{18'd256,  5'd4,  16'd10,  20'd10,  8'd0}, // R2 R6 plain count
        '{18'd256,  5'd4,  16'd37,  20'd5,   8'd2}, // R6 R7 wraps
        '{18'd384,  5'd3,  16'd30,  20'd4,   8'd2}, // R4 divide 1.5
        '{18'd100,  5'd5,  16'd40,  20'd8,   8'd1}, // R5 clamp to 1.0
        '{18'd640,  5'd2,  16'd25,  20'd2,   8'd2}, // R4 divide 2.5
        '{18'd1000, 5'd1,  16'd50,  20'd0,   8'd6}, // R4 divide 3.906
        '{18'd256,  5'd0,  16'd5,   20'd1,   8'd2}, // R6 res 0 -> 1
        '{18'd256,  5'd31, 16'd100, 20'd100, 8'd0}  // R6 res 31 -> 20
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock edge; land on the falling edge and tally strobes.
    task automatic cyc();
        @(negedge clk);
        if (ovf) ovf_seen++;
    endtask

    task automatic do_clr();
        cnt_clr = 1'b1;
        cyc();
        cnt_clr = 1'b0;
        ovf_seen = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 count after reset", int'(count), 0);
        check("R1 ovf after reset", int'(ovf), 0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            div_val  = VECS[i].div;
            res_bits = VECS[i].res;
            do_clr();
            for (int c = 0; c < int'(VECS[i].cycles); c++) cyc();
            check($sformatf("R4/R6 vector %0d count", i), int'(count), int'(VECS[i].exp_cnt));
            check($sformatf("R7 vector %0d ovf pulses", i), ovf_seen, int'(VECS[i].exp_ovf));
        end

        // R4 dithering: divide 1.5 gives spacing of 2 then 1 edges.
        div_val = 18'd384; res_bits = 5'd8;
        do_clr();
        cyc(); check("R4 dither k=1", int'(count), 0);
        cyc(); check("R4 dither k=2", int'(count), 1);
        cyc(); check("R4 dither k=3", int'(count), 2);
        cyc(); check("R4 dither k=4", int'(count), 2);
        cyc(); check("R4 dither k=5", int'(count), 3);

        // R8 pause holds; R9 clear wins over pause.
        div_val = 18'd256;
        do_clr();
        repeat (5) cyc();
        pause = 1'b1;
        repeat (10) cyc();
        check("R8 held during pause", int'(count), 5);
        pause = 1'b0;
        repeat (3) cyc();
        check("R8 resumes after pause", int'(count), 8);
        pause = 1'b1; cnt_clr = 1'b1;
        cyc();
        check("R9 clear over pause", int'(count), 0);
        pause = 1'b0; cnt_clr = 1'b0;

        // R3 reference source: only rising edges count.
        src_sel = 1'b1;
        do_clr();
        for (int p = 0; p < 6; p++) begin
            ref_tick = 1'b1; cyc();
            ref_tick = 1'b0; repeat (3) cyc();
        end
        check("R3 six reference pulses", int'(count), 6);
        ref_tick = 1'b1;
        repeat (10) cyc();
        ref_tick = 1'b0;
        cyc();
        check("R3 held level counts once", int'(count), 7);
        div_val = 18'd512;
        do_clr();
        for (int p = 0; p < 4; p++) begin
            ref_tick = 1'b1; cyc();
            ref_tick = 1'b0; repeat (2) cyc();
        end
        check("R3 reference with divide 2", int'(count), 2);
        src_sel = 1'b0;

        // R10 resolution change waits for wrap.
        div_val = 18'd256; res_bits = 5'd3;
        do_clr();
        repeat (5) cyc();
        res_bits = 5'd2;
        repeat (2) cyc();
        check("R10 old width kept", int'(count), 7);
        cyc();
        check("R10 wrap at old top", int'(count), 0);
        check("R7 strobe on wrap", int'(ovf), 1);
        repeat (3) cyc();
        check("R10 new width count", int'(count), 3);
        cyc();
        check("R10 wrap at new top", int'(count), 0);

        // R1 reset in mid-run.
        repeat (2) cyc();
        rst_n = 1'b0;
        cyc();
        check("R1 reset mid-run", int'(count), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule